// File: doc/BRIEF.md
# Configurable UART Character Transceiver

This block pairs an asynchronous serial transmitter with a matching receiver. Both sides share one 8-bit control register, which selects the character format, the transmit polarity, an internal loop-back path and a global enable. Characters of 8 or 9 payload bits are supported. When parity is on, the parity bit takes the place of the top payload bit. This gives four parity formats: 7 or 8 data bits, each with even or odd parity.

The host writes the control register and loads characters through a one-deep transmit buffer. It watches the ready flag to know when another character may be loaded, and the done flag to know when the line has gone quiet. Received characters appear right-aligned on a data output with a one-cycle valid pulse, a parity-error flag and a framing-error flag. The host supplies a baud tick at 16 times the bit rate. Every bit lasts 16 ticks in both directions.

Top module: `uart_xcvr`

## Requirements
- R1: After reset the control register reads 0x00, `tx_pin` is 1, `tx_ready` and `tx_done` are 1, and `rx_valid` is 0.
- R2: Control bit 7 selects loop-back, bit 6 enables the block, bit 5 inverts transmit, bit 4 selects 9-bit length, bit 1 enables parity and bit 0 selects odd parity (0 = even). Bits 3 and 2 are not stored and read 0, so writing 0xFF reads back 0xF3.
- R3: With bits 4 and 1 clear, a frame is a 0 start bit, then 8 data bits least significant first, then a 1 stop bit. Each bit lasts 16 baud ticks.
- R4: With bit 4 set and bit 1 clear, the frame carries 9 data bits (11 bits in total).
- R5: With bit 1 set, the frame carries 7 data bits (bit 4 = 0) or 8 data bits (bit 4 = 1), then a parity bit, then the stop bit. The parity bit makes the count of ones over data and parity even when bit 0 is 0, and odd when bit 0 is 1.
- R6: With bit 5 set, `tx_pin` is the complement of every line state, including idle. The idle level is then 0.
- R7: The receiver decodes the same formats and presents the data right-aligned in `rx_data`, with the unused upper bits at 0. `rx_valid` pulses for exactly one cycle per frame.
- R8: `rx_parity_err` is 1 with the character when the received parity bit does not match the selected parity, and 0 otherwise.
- R9: `rx_frame_err` is 1 with the character when the stop bit is sampled as 0.
- R10: With bit 7 set, `rx_pin` is ignored and the receiver takes the transmitter output before the inversion stage. A looped character is therefore received intact while bit 5 is set.
- R11: While bit 6 is 0, `tx_ready` and `tx_done` are forced to 1 and `tx_pin` rests at idle. Loads are ignored, any character in progress is dropped, and the receiver produces nothing.
- R12: A load while `tx_ready` is 1 fills the buffer, and `tx_ready` stays 0 until the shifter takes the character. A load while `tx_ready` is 0 is ignored. `tx_done` is 1 only when both the buffer and the shifter are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| tx_load | input | 1 | Load `tx_data` into the transmit buffer |
| tx_data | input | 9 | Character to transmit, right-aligned |
| tx_ready | output | 1 | Transmit buffer can accept a character |
| tx_done | output | 1 | Buffer and shifter both empty |
| tx_pin | output | 1 | Serial transmit line |
| rx_pin | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 9 | Last received character, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| rx_parity_err | output | 1 | Parity mismatch on the last character |
| rx_frame_err | output | 1 | Stop bit was 0 on the last character |

## Verification
The properties assume that the baud tick comes at least a few clocks apart, so that a frame spans many cycles and one valid pulse cannot follow another. They also assume that the control register does not change its format bits in the middle of a frame, since the receiver decodes with the current setting. The stimulus respects both assumptions. Its tick arrives every fourth clock. It changes the control register only while both directions are idle, except in the scenario that clears the enable on purpose during a transmission.

// File: rtl/uart_xcvr_pkg.sv
// Package: shared constants, control-field positions and the decoded
// configuration type for the UART transceiver.
package uart_xcvr_pkg;
    localparam int CTRL_W    = 8;
    localparam int DATA_W    = 9;
    localparam int OVS       = 16;
    localparam int OVS_W     = $clog2(OVS);
    localparam int FRAME_MAX = DATA_W + 2;
    localparam int FRM_W     = $clog2(FRAME_MAX + 1);

    localparam int POS_LOOP = 7;
    localparam int POS_EN   = 6;
    localparam int POS_INV  = 5;
    localparam int POS_LEN  = 4;
    localparam int POS_PEN  = 1;
    localparam int POS_ODD  = 0;

    localparam logic [CTRL_W-1:0] CTRL_MASK =
        CTRL_W'((1 << POS_LOOP) | (1 << POS_EN) | (1 << POS_INV) |
                (1 << POS_LEN) | (1 << POS_PEN) | (1 << POS_ODD));

    typedef struct packed {
        logic loop;
        logic en;
        logic inv;
        logic len9;
        logic par_en;
        logic par_odd;
    } cfg_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    // Number of bits between start and stop (data plus parity slot).
    function automatic logic [FRM_W-1:0] payload_len(input cfg_t c);
        return c.len9 ? FRM_W'(DATA_W) : FRM_W'(DATA_W - 1);
    endfunction
endpackage

// File: rtl/uart_xcvr_regs.sv
// Control register: holds the six implemented control bits and decodes
// them into the configuration struct. Unimplemented bits read 0.
// Assumes writes are single-cycle strobes in the clk domain.
module uart_xcvr_regs
    import uart_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output cfg_t              cfg
);
    logic [CTRL_W-1:0] ctrl_q;

    // Store the writable bits of a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q <= wdata & CTRL_MASK;
        end
    end

    // Decode the stored bits into named fields.
    always_comb begin
        rdata       = ctrl_q;
        cfg.loop    = ctrl_q[POS_LOOP];
        cfg.en      = ctrl_q[POS_EN];
        cfg.inv     = ctrl_q[POS_INV];
        cfg.len9    = ctrl_q[POS_LEN];
        cfg.par_en  = ctrl_q[POS_PEN];
        cfg.par_odd = ctrl_q[POS_ODD];
    end
endmodule

// File: rtl/uart_xcvr_sync.sv
// Multi-stage synchronizer for an asynchronous level into clk.
// Resets to the idle line level (1). Assumes the input is a slow level.
module uart_xcvr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_xcvr_tx.sv
// Transmitter: a one-deep holding buffer feeding a frame shifter. A frame is
// built when the shifter takes a character: start 0, data LSB first,
// optional parity in place of the top payload bit, stop 1. Each bit lasts
// OVS baud ticks. Output is the uninverted line. Assumes the format bits
// are stable while a frame is in flight.
module uart_xcvr_tx
    import uart_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              done,
    output logic              line_raw
);
    logic [DATA_W-1:0]    buf_q;
    logic                 buf_full_q;
    logic [FRAME_MAX-1:0] shift_q;
    logic                 busy_q;
    logic [OVS_W-1:0]     tick_q;
    logic [FRM_W-1:0]     left_q;

    logic [FRM_W-1:0]     pay_n;
    logic [FRM_W-1:0]     data_n;
    logic [DATA_W-1:0]    data_mask;
    logic                 par_bit;
    logic [FRAME_MAX-1:0] frame_w;

    // Frame image for the buffered character under the current format.
    always_comb begin
        pay_n  = payload_len(cfg);
        data_n = pay_n - FRM_W'(cfg.par_en);
        for (int i = 0; i < DATA_W; i++) begin
            data_mask[i] = (FRM_W'(i) < data_n);
        end
        par_bit    = (^(buf_q & data_mask)) ^ cfg.par_odd;
        frame_w    = '1;
        frame_w[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (FRM_W'(i) < data_n) begin
                frame_w[i+1] = buf_q[i];
            end else if (FRM_W'(i) == data_n && cfg.par_en) begin
                frame_w[i+1] = par_bit;
            end
        end
    end

    // Buffer fill, shifter hand-over and bit timing.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg.en) begin
            buf_q      <= '0;
            buf_full_q <= 1'b0;
            shift_q    <= '1;
            busy_q     <= 1'b0;
            tick_q     <= '0;
            left_q     <= '0;
        end else begin
            if (load && !buf_full_q) begin
                buf_q      <= data;
                buf_full_q <= 1'b1;
            end
            if (!busy_q && buf_full_q) begin
                shift_q    <= frame_w;
                busy_q     <= 1'b1;
                tick_q     <= '0;
                left_q     <= pay_n + FRM_W'(2);
                buf_full_q <= 1'b0;
            end else if (busy_q && baud_tick) begin
                if (tick_q == OVS_W'(OVS - 1)) begin
                    tick_q  <= '0;
                    shift_q <= {1'b1, shift_q[FRAME_MAX-1:1]};
                    left_q  <= left_q - FRM_W'(1);
                    if (left_q == FRM_W'(1)) begin
                        busy_q <= 1'b0;
                    end
                end else begin
                    tick_q <= tick_q + OVS_W'(1);
                end
            end
        end
    end

    // Flags are forced while disabled so they do not wait for the clear.
    assign ready    = !buf_full_q || !cfg.en;
    assign done     = (!buf_full_q && !busy_q) || !cfg.en;
    assign line_raw = busy_q ? shift_q[0] : 1'b1;
endmodule

// File: rtl/uart_xcvr_rx.sv
// Receiver: arms on a sampled 1, detects a falling line, confirms the start
// bit at mid-period, then samples each later bit every OVS ticks. At the
// stop bit it decodes data and parity and pulses valid. Assumes a
// synchronized input and format bits stable during a frame.
module uart_xcvr_rx
    import uart_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              baud_tick,
    input  logic              line,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              perr,
    output logic              ferr
);
    localparam int HALF = OVS / 2;

    rx_state_t         state_q;
    logic              armed_q;
    logic [OVS_W-1:0]  cnt_q;
    logic [FRM_W-1:0]  bitn_q;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              perr_q;
    logic              ferr_q;

    logic [FRM_W-1:0]  pay_n;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] dec_data;
    logic              dec_perr;

    // Align the shifted bits and split data from parity.
    always_comb begin
        pay_n    = payload_len(cfg);
        raw      = cfg.len9 ? shift_q : {1'b0, shift_q[DATA_W-1:1]};
        dec_data = raw;
        dec_perr = 1'b0;
        if (cfg.par_en) begin
            if (cfg.len9) begin
                dec_data = {1'b0, raw[DATA_W-2:0]};
                dec_perr = (^raw[DATA_W-2:0]) ^ raw[DATA_W-1] ^ cfg.par_odd;
            end else begin
                dec_data = {2'b00, raw[DATA_W-3:0]};
                dec_perr = (^raw[DATA_W-3:0]) ^ raw[DATA_W-2] ^ cfg.par_odd;
            end
        end
    end

    // Frame state machine, sampling on baud ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg.en) begin
            state_q <= RX_IDLE;
            armed_q <= 1'b0;
            cnt_q   <= '0;
            bitn_q  <= '0;
            shift_q <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (baud_tick) begin
                unique case (state_q)
                    RX_IDLE: begin
                        armed_q <= line;
                        if (armed_q && !line) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == OVS_W'(HALF - 1)) begin
                            cnt_q  <= '0;
                            bitn_q <= '0;
                            if (!line) begin
                                state_q <= RX_DATA;
                            end else begin
                                state_q <= RX_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + OVS_W'(1);
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == OVS_W'(OVS - 1)) begin
                            cnt_q   <= '0;
                            shift_q <= {line, shift_q[DATA_W-1:1]};
                            bitn_q  <= bitn_q + FRM_W'(1);
                            if (bitn_q == pay_n - FRM_W'(1)) begin
                                state_q <= RX_STOP;
                            end
                        end else begin
                            cnt_q <= cnt_q + OVS_W'(1);
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == OVS_W'(OVS - 1)) begin
                            cnt_q   <= '0;
                            state_q <= RX_IDLE;
                            armed_q <= line;
                            valid_q <= 1'b1;
                            data_q  <= dec_data;
                            perr_q  <= dec_perr;
                            ferr_q  <= !line;
                        end else begin
                            cnt_q <= cnt_q + OVS_W'(1);
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign data  = data_q;
    assign valid = valid_q;
    assign perr  = perr_q;
    assign ferr  = ferr_q;
endmodule

// File: rtl/uart_xcvr.sv
// Top: control register, transmitter, receiver and the loop-back and
// inversion paths. Loop-back taps the transmitter before inversion.
// Assumes rx_pin is asynchronous and baud_tick is a clk-domain pulse.
module uart_xcvr
    import uart_xcvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              reg_we,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              tx_done,
    output logic              tx_pin,
    input  logic              rx_pin,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err,
    output logic              rx_frame_err
);
    cfg_t cfg;
    logic tx_raw;
    logic rx_src;
    logic rx_line;

    uart_xcvr_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    uart_xcvr_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .baud_tick (baud_tick),
        .load      (tx_load),
        .data      (tx_data),
        .ready     (tx_ready),
        .done      (tx_done),
        .line_raw  (tx_raw)
    );

    // Receiver source: internal transmitter line in loop-back, else the pin.
    assign rx_src = cfg.loop ? tx_raw : rx_pin;

    uart_xcvr_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_src),
        .dout  (rx_line)
    );

    uart_xcvr_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .baud_tick (baud_tick),
        .line      (rx_line),
        .data      (rx_data),
        .valid     (rx_valid),
        .perr      (rx_parity_err),
        .ferr      (rx_frame_err)
    );

    // Output stage: idle while disabled, then optional inversion.
    assign tx_pin = (cfg.en ? tx_raw : 1'b1) ^ cfg.inv;
endmodule

// File: rtl/uart_xcvr_chk.sv
// Checker: temporal properties on the transceiver ports, bound to the top.
module uart_xcvr_chk
    import uart_xcvr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] reg_rdata,
    input logic              tx_load,
    input logic              tx_ready,
    input logic              tx_done,
    input logic              tx_pin,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data
);
    // R11
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[POS_EN] |-> (tx_ready && tx_done && (tx_pin == !reg_rdata[POS_INV])));

    // R12
    done_has_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_ready);

    // R12
    ready_fall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> $past(tx_load));

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    short_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !reg_rdata[POS_LEN]) |-> (rx_data[DATA_W-1] == 1'b0));
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .tx_load   (tx_load),
    .tx_ready  (tx_ready),
    .tx_done   (tx_done),
    .tx_pin    (tx_pin),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data)
);

// File: tb/uart_xcvr_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module uart_xcvr_tb;
    localparam int BIT_CLK = 64;  // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_load = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_ready, tx_done, tx_pin;
    logic       rx_pin = 1'b1;
    logic [8:0] rx_data;
    logic       rx_valid, rx_parity_err, rx_frame_err;

    int checks = 0;
    int errors = 0;
    int got_cnt = 0;
    logic [8:0] got_data = '0;
    logic got_perr = 1'b0;
    logic got_ferr = 1'b0;

    uart_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_load(tx_load), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_done(tx_done), .tx_pin(tx_pin), .rx_pin(rx_pin),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
    );

    initial forever #10 clk = ~clk;  // 50 MHz

    // Baud tick every fourth clock.
    initial forever begin
        repeat (3) @(negedge clk);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    end

    // Record each received character.
    always @(negedge clk) begin
        if (rx_valid) begin
            got_cnt  = got_cnt + 1;
            got_data = rx_data;
            got_perr = rx_parity_err;
            got_ferr = rx_frame_err;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected frame from the format rules, bit 0 first on the line.
    function automatic logic [10:0] make_frame(input logic len9, input logic pen,
                                               input logic odd, input logic [8:0] d,
                                               output int n);
        logic [10:0] f;
        int nd;
        int k;
        logic p;
        f = '1;
        f[0] = 1'b0;
        nd = (len9 ? 9 : 8) - (pen ? 1 : 0);
        k = 1;
        p = odd;
        for (int i = 0; i < nd; i++) begin
            f[k] = d[i];
            p = p ^ d[i];
            k++;
        end
        if (pen) begin
            f[k] = p;
            k++;
        end
        f[k] = 1'b1;
        n = k + 1;
        return f;
    endfunction

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load(input logic [8:0] d);
        @(negedge clk);
        tx_load = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!tx_done && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // Sample one frame off tx_pin at mid-bit, undoing inversion.
    task automatic cap_tx(input logic inv, input int n, output logic [10:0] got);
        int t = 0;
        got = '1;
        while (tx_pin === (1'b1 ^ inv) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 3000) begin
            got = '0;
            return;
        end
        repeat (BIT_CLK / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = tx_pin ^ inv;
            if (i < n - 1) repeat (BIT_CLK) @(negedge clk);
        end
    endtask

    task automatic tx_case(input string req, input logic [7:0] ctrl, input logic [8:0] d);
        logic [10:0] exp, got, mask;
        int n;
        wr(ctrl);
        exp = make_frame(ctrl[4], ctrl[1], ctrl[0], d, n);
        mask = 11'((1 << n) - 1);
        load(d);
        cap_tx(ctrl[5], n, got);
        chk(req, 32'(got & mask), 32'(exp & mask));
        wait_done();
    endtask

    task automatic drive_rx(input logic [10:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            rx_pin = f[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        rx_pin = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic rx_case(input string req, input logic [7:0] ctrl, input logic [10:0] f,
                           input int n, input logic [8:0] ed, input logic ep, input logic ef);
        int c0;
        wr(ctrl);
        rx_pin = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
        c0 = got_cnt;
        drive_rx(f, n);
        chk({req, " count"}, 32'(got_cnt - c0), 1);
        chk({req, " data"}, 32'(got_data), 32'(ed));
        chk({req, " perr"}, 32'(got_perr), 32'(ep));
        chk({req, " ferr"}, 32'(got_ferr), 32'(ef));
    endtask

    task automatic test_reset();
        chk("R1 ctrl", 32'(reg_rdata), 0);
        chk("R1 tx_pin", 32'(tx_pin), 1);
        chk("R1 ready", 32'(tx_ready), 1);
        chk("R1 done", 32'(tx_done), 1);
        chk("R1 valid", 32'(rx_valid), 0);
    endtask

    task automatic test_reg();
        wr(8'hFF);
        chk("R2 readback", 32'(reg_rdata), 32'h F3);
        wr(8'h00);
        chk("R2 clear", 32'(reg_rdata), 0);
    endtask

    task automatic test_tx_formats();
        tx_case("R3 8N1", 8'h40, 9'h05A);
        tx_case("R3 8N1 b", 8'h40, 9'h1FF);
        tx_case("R4 9N1", 8'h50, 9'h1A5);
        tx_case("R5 7E", 8'h42, 9'h053);
        tx_case("R5 7O", 8'h43, 9'h053);
        tx_case("R5 8E", 8'h52, 9'h0C7);
        tx_case("R5 8O", 8'h53, 9'h0C7);
    endtask

    task automatic test_invert();
        wr(8'h60);
        repeat (4) @(negedge clk);
        chk("R6 idle level", 32'(tx_pin), 0);
        tx_case("R6 inverted frame", 8'h60, 9'h0B2);
    endtask

    task automatic test_rx();
        logic [10:0] f;
        int n;
        f = make_frame(1'b0, 1'b0, 1'b0, 9'h03C, n);
        rx_case("R7 8N1", 8'h40, f, n, 9'h03C, 1'b0, 1'b0);
        f = make_frame(1'b1, 1'b0, 1'b0, 9'h1C3, n);
        rx_case("R7 9N1", 8'h50, f, n, 9'h1C3, 1'b0, 1'b0);
        f = make_frame(1'b0, 1'b1, 1'b0, 9'h035, n);
        rx_case("R7 7E", 8'h42, f, n, 9'h035, 1'b0, 1'b0);
        f = make_frame(1'b1, 1'b1, 1'b1, 9'h0E1, n);
        rx_case("R8 8O good", 8'h53, f, n, 9'h0E1, 1'b0, 1'b0);
        f[9] = ~f[9];
        rx_case("R8 8O bad", 8'h53, f, n, 9'h0E1, 1'b1, 1'b0);
        f = make_frame(1'b0, 1'b0, 1'b0, 9'h081, n);
        f[9] = 1'b0;
        rx_case("R9 stop low", 8'h40, f, n, 9'h081, 1'b0, 1'b1);
    endtask

    task automatic test_loop();
        int c0;
        wr(8'hE0);
        rx_pin = 1'b0;
        repeat (8) @(negedge clk);
        chk("R10 inverted idle", 32'(tx_pin), 0);
        c0 = got_cnt;
        load(9'h0A5);
        repeat (4) @(negedge clk);
        wait_done();
        repeat (BIT_CLK) @(negedge clk);
        chk("R10 loop count", 32'(got_cnt - c0), 1);
        chk("R10 loop data", 32'(got_data), 32'h A5);
        chk("R10 loop ferr", 32'(got_ferr), 0);
        rx_pin = 1'b1;
        wr(8'h40);
    endtask

    task automatic test_disable();
        int lows = 0;
        int c0;
        logic [10:0] f;
        int n;
        wr(8'h40);
        load(9'h000);
        repeat (100) @(negedge clk);
        wr(8'h00);
        chk("R11 ready", 32'(tx_ready), 1);
        chk("R11 done", 32'(tx_done), 1);
        chk("R11 pin idle", 32'(tx_pin), 1);
        load(9'h055);
        c0 = got_cnt;
        f = make_frame(1'b0, 1'b0, 1'b0, 9'h0F0, n);
        fork
            drive_rx(f, n);
            for (int i = 0; i < 800; i++) begin
                @(negedge clk);
                if (tx_pin !== 1'b1) lows++;
            end
        join
        chk("R11 no tx", 32'(lows), 0);
        chk("R11 no rx", 32'(got_cnt - c0), 0);
        wr(8'h40);
        lows = 0;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (tx_pin !== 1'b1) lows++;
        end
        chk("R11 dropped on enable", 32'(lows), 0);
    endtask

    task automatic test_buffer();
        logic [10:0] ga, gb, ea, eb;
        int n;
        int lows = 0;
        wr(8'h40);
        ea = make_frame(1'b0, 1'b0, 1'b0, 9'h011, n);
        eb = make_frame(1'b0, 1'b0, 1'b0, 9'h0EE, n);
        fork
            begin
                cap_tx(1'b0, n, ga);
                cap_tx(1'b0, n, gb);
            end
            begin
                load(9'h011);
                load(9'h0EE);
                chk("R12 ready low", 32'(tx_ready), 0);
                chk("R12 done low", 32'(tx_done), 0);
                load(9'h0AA);
            end
        join
        chk("R12 first", 32'(ga & 11'h3FF), 32'(ea & 11'h3FF));
        chk("R12 second", 32'(gb & 11'h3FF), 32'(eb & 11'h3FF));
        wait_done();
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (tx_pin !== 1'b1) lows++;
        end
        chk("R12 extra ignored", 32'(lows), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_reg();
        test_tx_formats();
        test_invert();
        test_rx();
        test_loop();
        test_disable();
        test_buffer();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule